// File: doc/BRIEF.md
# Configurable Serial Receiver with Line Deglitch

This block turns an asynchronous serial line into data characters. The line is synchronised to the system clock and then filtered, so that short pulses never reach the character logic. A falling edge of the filtered line starts a character. Each bit is sampled at its midpoint, with the bit period set by a clock-count divisor. When the character is complete, the block presents the received data together with a one-cycle valid strobe.

An 8-bit configuration word sets the frame. It selects the data length, whether a parity bit is present, the parity sense and the number of stop bits. One bit of the word holds the receiver in reset. Two further bits are reserved for the transmit side and have no effect here. Framing and parity problems are flagged by strobes that occur in the same cycle as the valid strobe. A line held low for a whole character raises a break flag, and that flag stays set until the line goes high again.

Top module: `serial_rx_filt`

## Requirements
- R1: After `rst`, `byte_valid`, `frame_err`, `parity_err` and `break_flag` are all low, and they stay low while the line stays idle high.
- R2: A character is a low start bit followed by data bits sent least significant bit first, each bit lasting `baud_div` clocks. Every bit is sampled half a bit period after the filtered start edge plus a whole number of bit periods.
- R3: `frame_cfg[4:3]` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `byte_out` above the data length read zero.
- R4: `frame_cfg[2]`=1 adds a parity bit after the data. `frame_cfg[1]`=0 selects even parity and 1 selects odd parity. `parity_err` pulses when the ones in the data and parity bits together do not match the selected sense.
- R5: `frame_cfg[0]` selects one stop bit (0) or two stop bits (1). A low level at any stop-bit sample makes `frame_err` pulse.
- R6: For each character, `byte_valid` is high for exactly one clock. `frame_err` and `parity_err` are only ever high in that same clock.
- R7: Line pulses shorter than 2^FILT_BITS clocks, measured after the two-flop synchroniser, are ignored and start no character.
- R8: A start bit that is no longer low at its midpoint sample is dropped. No character is produced from it.
- R9: If every sample of a character is low, including the parity and stop samples, the character is delivered as zero with `frame_err`, and `break_flag` is set. `break_flag` stays high while the line stays low and clears once the filtered line is high again.
- R10: While `frame_cfg[7]` or `rst` is high, the receiver returns to idle and produces no strobe, and any character in progress is abandoned. `frame_cfg[6:5]` have no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_cfg | input | 8 | Frame configuration word |
| baud_div | input | DIV_W | Clocks per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| byte_out | output | 8 | Received data, right aligned |
| byte_valid | output | 1 | One-cycle strobe for each character |
| frame_err | output | 1 | Stop-bit error strobe |
| parity_err | output | 1 | Parity mismatch strobe |
| break_flag | output | 1 | Held high during a line break |

## Verification
The hardest situation to produce is a false start that gets past the filter but dies before the midpoint sample. It needs a low pulse longer than 2^FILT_BITS clocks and shorter than half a bit. The stimulus makes one 5 clocks wide, with a 16-clock bit period, and then sends a normal character to show that the receiver is back in idle. A break is reached by holding the line low well past the end of a zero character. Abandoning a character is tested by setting the configuration reset bit in the middle of a data bit.

// File: rtl/serial_rx_filt.sv
module serial_rx_filt #(
  parameter int DIV_W     = 17,
  parameter int FILT_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       frame_cfg,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rx_line,
  output logic [7:0]       byte_out,
  output logic             byte_valid,
  output logic             frame_err,
  output logic             parity_err,
  output logic             break_flag
);
  localparam logic [FILT_BITS-1:0] FMAX = {FILT_BITS{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  wire clr = rst | frame_cfg[7];

  logic [1:0]           sync;
  logic                 line_f, line_q;
  logic [FILT_BITS-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      sync   <= 2'b11;
      line_f <= 1'b1;
      line_q <= 1'b1;
      fcnt   <= '0;
    end else begin
      sync   <= {sync[0], rx_line};
      line_q <= line_f;
      if (sync[1] != line_f) begin
        if (fcnt == FMAX) begin
          line_f <= sync[1];
          fcnt   <= '0;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end else begin
        fcnt <= '0;
      end
    end
  end

  st_t              st;
  logic [DIV_W-1:0] tcnt;
  logic [2:0]       idx;
  logic [7:0]       dat;
  logic             par, perr_r, all_low, stop_bad, stops_left;

  wire       tick     = (tcnt == '0);
  wire [2:0] last_idx = {1'b1, frame_cfg[4:3]};
  wire       bad_now  = stop_bad | ~line_f;
  wire       low_now  = all_low & ~line_f;

  always_ff @(posedge clk) begin
    if (clr) begin
      st         <= S_IDLE;
      tcnt       <= '0;
      idx        <= '0;
      dat        <= '0;
      par        <= 1'b0;
      perr_r     <= 1'b0;
      all_low    <= 1'b0;
      stop_bad   <= 1'b0;
      stops_left <= 1'b0;
      byte_out   <= '0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      break_flag <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      if (st != S_IDLE && st != S_BRK)
        tcnt <= tick ? baud_div - 1'b1 : tcnt - 1'b1;
      case (st)
        S_IDLE: if (line_q && !line_f) begin
          st       <= S_START;
          tcnt     <= baud_div >> 1;
          idx      <= '0;
          dat      <= '0;
          par      <= 1'b0;
          perr_r   <= 1'b0;
          all_low  <= 1'b1;
          stop_bad <= 1'b0;
        end
        S_START: if (tick) st <= line_f ? S_IDLE : S_DATA;
        S_DATA: if (tick) begin
          dat[idx] <= line_f;
          par      <= par ^ line_f;
          all_low  <= low_now;
          if (idx == last_idx) begin
            st         <= frame_cfg[2] ? S_PAR : S_STOP;
            stops_left <= frame_cfg[0];
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PAR: if (tick) begin
          perr_r     <= (par ^ line_f) != frame_cfg[1];
          all_low    <= low_now;
          stops_left <= frame_cfg[0];
          st         <= S_STOP;
        end
        S_STOP: if (tick) begin
          if (stops_left) begin
            stops_left <= 1'b0;
            stop_bad   <= bad_now;
            all_low    <= low_now;
          end else begin
            byte_valid <= 1'b1;
            byte_out   <= dat;
            frame_err  <= bad_now;
            parity_err <= perr_r;
            if (low_now) begin
              break_flag <= 1'b1;
              st         <= S_BRK;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_BRK: if (line_f) begin
          break_flag <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);  // R6
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    (frame_err || parity_err) |-> byte_valid);  // R6
  AST_BYTE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> ((byte_out >> (5 + frame_cfg[4:3])) == 8'd0));  // R3
  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(break_flag) |-> (frame_err && byte_out == 8'd0));  // R9
  AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (rst || frame_cfg[7])
    (break_flag && !line_f) |=> break_flag);  // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    frame_cfg[7] |=> (!byte_valid && !break_flag && st == S_IDLE));  // R10
endmodule

// File: tb/serial_rx_filt_tb.sv
module serial_rx_filt_tb;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg = 8'h18;
  logic [16:0] div = 17'(DIV);
  logic        rx  = 1'b1;
  logic [7:0]  byte_out;
  logic        byte_valid, frame_err, parity_err, break_flag;

  int checks = 0, fails = 0, vcount = 0, wide = 0;
  logic [7:0] cap_byte;
  logic cap_fe, cap_pe, prev_v = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  serial_rx_filt #(.DIV_W(17), .FILT_BITS(2)) u_dut (
    .clk(clk), .rst(rst), .frame_cfg(cfg), .baud_div(div), .rx_line(rx),
    .byte_out(byte_out), .byte_valid(byte_valid), .frame_err(frame_err),
    .parity_err(parity_err), .break_flag(break_flag));

  always @(negedge clk) begin
    if (byte_valid) begin
      vcount++;
      cap_byte = byte_out;
      cap_fe = frame_err;
      cap_pe = parity_err;
      if (prev_v) wide++;
    end
    prev_v = byte_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitp(input logic v);
    rx = v;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int n;
    logic p;
    n = 5 + c[4:3];
    p = c[1];
    @(negedge clk);
    bitp(1'b0);
    for (int i = 0; i < n; i++) begin
      bitp(d[i]);
      p ^= d[i];
    end
    if (c[2]) bitp(p ^ bad_par);
    bitp(!bad_stop);
    if (c[0]) bitp(1'b1);
    rx = 1'b1;
    repeat (2 * DIV) @(negedge clk);
  endtask

  localparam logic [17:0] VEC [10] = '{
    {8'h18, 8'hA5, 2'b00}, {8'h00, 8'h35, 2'b00}, {8'h08, 8'hFF, 2'b00},
    {8'h10, 8'h5A, 2'b00}, {8'h1C, 8'h81, 2'b00}, {8'h1E, 8'h81, 2'b10},
    {8'h19, 8'h3C, 2'b01}, {8'h78, 8'hC3, 2'b00}, {8'h0E, 8'h13, 2'b00},
    {8'h18, 8'h7E, 2'b01}};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] c, d, mask;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(!byte_valid && !frame_err && !parity_err && !break_flag && vcount == 0, "R1 reset state",
        {byte_valid, frame_err, parity_err, break_flag}, 0);

    for (int k = 0; k < 10; k++) begin
      c = VEC[k][17:10];
      d = VEC[k][9:2];
      cfg = c;
      mask = 8'hFF >> (3 - c[4:3]);
      base = vcount;
      send(c, d, VEC[k][1], VEC[k][0]);
      chk(vcount == base + 1, "R6 one strobe per char", vcount - base, 1);
      chk(cap_byte == (d & mask), "R2/R3 data", cap_byte, d & mask);
      chk(cap_pe == VEC[k][1], "R4 parity strobe", cap_pe, VEC[k][1]);
      chk(cap_fe == VEC[k][0], "R5 stop strobe", cap_fe, VEC[k][0]);
    end
    chk(wide == 0, "R6 strobe width", wide, 0);

    cfg = 8'h18;
    base = vcount;
    @(negedge clk);
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    chk(vcount == base, "R7 glitch ignored", vcount - base, 0);
    send(8'h18, 8'h42, 1'b0, 1'b0);
    chk(vcount == base + 1 && cap_byte == 8'h42, "R7 char after glitch", cap_byte, 8'h42);

    base = vcount;
    @(negedge clk);
    rx = 1'b0;
    repeat (5) @(negedge clk);
    rx = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    chk(vcount == base, "R8 false start dropped", vcount - base, 0);
    send(8'h18, 8'h99, 1'b0, 1'b0);
    chk(vcount == base + 1 && cap_byte == 8'h99, "R8 char after false start", cap_byte, 8'h99);

    base = vcount;
    @(negedge clk);
    rx = 1'b0;
    repeat (14 * DIV) @(negedge clk);
    chk(break_flag == 1'b1, "R9 break held", break_flag, 1);
    chk(vcount == base + 1 && cap_byte == 8'h00 && cap_fe, "R9 zero char with frame error",
        {cap_fe, cap_byte}, 9'h100);
    rx = 1'b1;
    repeat (20) @(negedge clk);
    chk(break_flag == 1'b0, "R9 break cleared", break_flag, 0);

    base = vcount;
    @(negedge clk);
    rx = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    cfg = 8'h98;
    rx = 1'b1;
    repeat (2) @(negedge clk);
    cfg = 8'h18;
    repeat (12 * DIV) @(negedge clk);
    chk(vcount == base && !break_flag, "R10 char abandoned", vcount - base, 0);
    send(8'h18, 8'h3D, 1'b0, 1'b0);
    chk(vcount == base + 1 && cap_byte == 8'h3D, "R10 char after soft reset", cap_byte, 8'h3D);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule